// File: doc/BRIEF.md
# Serial Receive Holding Register and Status Flags

This block owns the receive side of a serial port once the bits are assembled. A deserializer pulses `rx_done_i` with the assembled word on `rx_shift_i`. When the receiver is enabled and nothing blocks it, the word moves into a holding register that software can read, and a data-ready flag is raised. If a second word completes while the first has not been taken, the block keeps the first word, drops the new one and latches an overrun flag. It then stalls the receiver and, in clocked synchronous mode, the transmitter as well.

Software clears the flags with a two-step handshake. It reads the status register, which captures one arm bit per flag for each flag seen as one. Its next status write then clears each armed flag whose write bit is zero. A DMA or transfer engine that takes the word pulses `dma_clr_i` to drop the data-ready flag directly. Two requests come from the flags: a receive request driven by data-ready and an error request driven by overrun, both gated by one interrupt-enable input. Power-on reset and a standby input both clear the flags.

Top module: `rxstat_ctrl`

## Requirements
- R1: After reset, and one cycle after `standby_i` is high, both flags read 0 (status bit 0 = data-ready, bit 1 = overrun, other bits 0). Standby leaves `rdata_o` unchanged. Reset clears `rdata_o` to 0.
- R2: `rx_done_i` with `rx_en_i`=1, overrun clear and data-ready clear loads `rx_shift_i` into `rdata_o` and sets data-ready on the next cycle.
- R3: `rx_done_i` while enabled, with data-ready=1 and no clear of data-ready in the same cycle, sets overrun. `rdata_o` keeps the earlier word.
- R4: A status write clears a flag only when that flag was read as one by an earlier status read and the written bit is 0. A zero write with no such read, and any write of 1, leave the flag unchanged.
- R5: Each status write consumes all arm bits. A second zero write without a new read does not clear anything.
- R6: A pulse on `dma_clr_i` clears data-ready.
- R7: While overrun=1, `rx_done_i` is ignored and `rx_stall_o`=1.
- R8: `tx_stall_o`=1 only when overrun=1 and `sync_mode_i`=1 (1 = clocked synchronous, 0 = asynchronous).
- R9: While `rx_en_i`=0, `rx_done_i` has no effect, and `rdata_o` and both flags keep their values.
- R10: If `rx_done_i` arrives in the same cycle as a software or DMA clear of data-ready, the new word is loaded, data-ready stays 1 and overrun stays 0.
- R11: `rxi_o` = data-ready AND `irq_en_i`. `eri_o` = overrun AND `irq_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Standby: clears both flags and arm bits |
| sync_mode_i | input | 1 | 1 = clocked synchronous mode, 0 = asynchronous |
| rx_en_i | input | 1 | Receiver enable |
| rx_done_i | input | 1 | Receive-complete pulse from the deserializer |
| rx_shift_i | input | DATA_W | Assembled word from the shift register |
| dma_clr_i | input | 1 | Clear strobe for data-ready from a DMA or transfer engine |
| stat_rd_i | input | 1 | Status register read strobe |
| stat_wr_i | input | 1 | Status register write strobe |
| stat_wdata_i | input | STAT_W | Status write data |
| irq_en_i | input | 1 | Receive interrupt enable |
| rdata_o | output | DATA_W | Holding register |
| status_o | output | STAT_W | Status: bit 0 data-ready, bit 1 overrun |
| rxi_o | output | 1 | Receive data interrupt request |
| eri_o | output | 1 | Receive error interrupt request |
| rx_stall_o | output | 1 | Receiver inhibit |
| tx_stall_o | output | 1 | Transmitter inhibit in synchronous mode |

## Verification
A wrong flag or arm bit shows at `status_o` and at the request and stall outputs one cycle after the strobe that misused it. A lost arm turns a valid clear into a no-op. A stale arm lets a bare zero write clear a flag. A bad load decision shows one cycle later as a changed `rdata_o` under overrun or under a disabled receiver, or as a spurious overrun when a clear and a reception coincide. The bench forces each of these coincidences and compares every output on the cycle after the stimulus.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;
  localparam int unsigned FLAG_RDY = 0;
  localparam int unsigned FLAG_OVR = 1;
  localparam int unsigned NFLAGS   = 2;

  typedef enum logic {
    MODE_ASYNC = 1'b0,
    MODE_SYNC  = 1'b1
  } mode_e;
endpackage

// File: rtl/rxstat_accept.sv
// Decides, per cycle, whether a completed word is loaded or lost to overrun.
module rxstat_accept (
  input  logic rx_done_i,
  input  logic rx_en_i,
  input  logic rdy_i,
  input  logic ovr_i,
  input  logic rdy_clr_i,
  output logic load_o,
  output logic set_ovr_o
);
  logic take;

  always_comb begin
    take      = rx_done_i & rx_en_i & ~ovr_i;
    load_o    = take & (~rdy_i | rdy_clr_i);
    set_ovr_o = take & rdy_i & ~rdy_clr_i;
  end
endmodule

// File: rtl/rxstat_datareg.sv
// Holding register with explicit load enable.
module rxstat_datareg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o
);
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    data_d = data_q;
    if (load_i) data_d = din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (load_i) data_q <= data_d;
  end

  assign dout_o = data_q;
endmodule

// File: rtl/rxstat_flag.sv
// One status flag with its read-as-one arm bit.
module rxstat_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic standby_i,
  input  logic set_i,
  input  logic hw_clr_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o,
  output logic sw_clr_o
);
  logic flag_q, flag_d, flag_en;
  logic arm_q, arm_d, arm_en;
  logic sw_clr;

  always_comb begin
    sw_clr = wr_i & ~wbit_i & arm_q & flag_q;

    flag_d = flag_q;
    if (standby_i)                flag_d = 1'b0;
    else if (set_i)               flag_d = 1'b1;
    else if (sw_clr || hw_clr_i)  flag_d = 1'b0;
    flag_en = standby_i | set_i | sw_clr | hw_clr_i;

    arm_d = arm_q;
    if (standby_i)  arm_d = 1'b0;
    else if (rd_i)  arm_d = flag_q;
    else if (wr_i)  arm_d = 1'b0;
    arm_en = standby_i | rd_i | wr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      arm_q <= 1'b0;
    else if (arm_en) arm_q <= arm_d;
  end

  assign flag_o   = flag_q;
  assign sw_clr_o = sw_clr;
endmodule

// File: rtl/rxstat_ctrl.sv
module rxstat_ctrl
  import rxstat_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby_i,
  input  logic              sync_mode_i,
  input  logic              rx_en_i,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_shift_i,
  input  logic              dma_clr_i,
  input  logic              stat_rd_i,
  input  logic              stat_wr_i,
  input  logic [STAT_W-1:0] stat_wdata_i,
  input  logic              irq_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [STAT_W-1:0] status_o,
  output logic              rxi_o,
  output logic              eri_o,
  output logic              rx_stall_o,
  output logic              tx_stall_o
);
  logic [NFLAGS-1:0] flag_set, flag_hwclr, flag_val, flag_swclr;
  logic load, set_ovr, rdy_clr;
  mode_e mode;

  assign mode    = mode_e'(sync_mode_i);
  assign rdy_clr = flag_swclr[FLAG_RDY] | dma_clr_i;

  rxstat_accept u_accept (
    .rx_done_i (rx_done_i),
    .rx_en_i   (rx_en_i),
    .rdy_i     (flag_val[FLAG_RDY]),
    .ovr_i     (flag_val[FLAG_OVR]),
    .rdy_clr_i (rdy_clr),
    .load_o    (load),
    .set_ovr_o (set_ovr)
  );

  rxstat_datareg #(.DATA_W(DATA_W)) u_data (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .din_i  (rx_shift_i),
    .dout_o (rdata_o)
  );

  always_comb begin
    flag_set             = '0;
    flag_hwclr           = '0;
    flag_set[FLAG_RDY]   = load;
    flag_hwclr[FLAG_RDY] = dma_clr_i;
    flag_set[FLAG_OVR]   = set_ovr;
  end

  for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
    rxstat_flag u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .standby_i (standby_i),
      .set_i     (flag_set[g]),
      .hw_clr_i  (flag_hwclr[g]),
      .rd_i      (stat_rd_i),
      .wr_i      (stat_wr_i),
      .wbit_i    (stat_wdata_i[g]),
      .flag_o    (flag_val[g]),
      .sw_clr_o  (flag_swclr[g])
    );
  end

  always_comb begin
    status_o              = '0;
    status_o[NFLAGS-1:0]  = flag_val;
    rxi_o      = flag_val[FLAG_RDY] & irq_en_i;
    eri_o      = flag_val[FLAG_OVR] & irq_en_i;
    rx_stall_o = flag_val[FLAG_OVR];
    tx_stall_o = flag_val[FLAG_OVR] & (mode == MODE_SYNC);
  end
endmodule

// File: rtl/rxstat_ctrl_chk.sv
module rxstat_ctrl_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned STAT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              standby_i,
  input logic              sync_mode_i,
  input logic              rx_en_i,
  input logic              rx_done_i,
  input logic              dma_clr_i,
  input logic              stat_wr_i,
  input logic [STAT_W-1:0] stat_wdata_i,
  input logic              irq_en_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [STAT_W-1:0] status_o,
  input logic              rxi_o,
  input logic              rx_stall_o,
  input logic              tx_stall_o
);
  assert_standby_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> (status_o[1:0] == 2'b00));

  assert_overrun_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done_i && rx_en_i && status_o[0] && !status_o[1] && !dma_clr_i
     && !stat_wr_i && !standby_i) |=> status_o[1]);

  assert_overrun_keeps_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[1] |=> $stable(rdata_o));

  assert_write_one_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr_i && stat_wdata_i[0] && status_o[0] && !dma_clr_i && !standby_i)
    |=> status_o[0]);

  assert_rx_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stall_o |-> status_o[1]);

  assert_tx_stall_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stall_o |-> (sync_mode_i && status_o[1]));

  assert_disabled_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_i |=> $stable(rdata_o));

  assert_coincident_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done_i && rx_en_i && status_o[0] && !status_o[1] && dma_clr_i && !standby_i)
    |=> (status_o[0] && !status_o[1]));

  assert_rxi_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rxi_o |-> (status_o[0] && irq_en_i));
endmodule

bind rxstat_ctrl rxstat_ctrl_chk #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .standby_i    (standby_i),
  .sync_mode_i  (sync_mode_i),
  .rx_en_i      (rx_en_i),
  .rx_done_i    (rx_done_i),
  .dma_clr_i    (dma_clr_i),
  .stat_wr_i    (stat_wr_i),
  .stat_wdata_i (stat_wdata_i),
  .irq_en_i     (irq_en_i),
  .rdata_o      (rdata_o),
  .status_o     (status_o),
  .rxi_o        (rxi_o),
  .rx_stall_o   (rx_stall_o),
  .tx_stall_o   (tx_stall_o)
);

// File: tb/rxstat_ctrl_tb.sv
`timescale 1ns/1ps
module rxstat_ctrl_tb;
  localparam int DW = 8;
  localparam int SW = 8;

  logic clk, rst_n;
  logic standby, sync_mode, rx_en, rx_done, dma_clr, st_rd, st_wr, irq_en;
  logic [DW-1:0] rx_shift, rdata;
  logic [SW-1:0] st_wdata, status;
  logic rxi, eri, rx_stall, tx_stall;

  logic en_q, sync_q, rie_q;
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    string         tag;
    logic [DW-1:0] data;
    logic [SW-1:0] stat;
    logic          rxi, eri, rst, tst;
  } exp_t;
  exp_t q[$];

  rxstat_ctrl #(.DATA_W(DW), .STAT_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .standby_i(standby), .sync_mode_i(sync_mode),
    .rx_en_i(rx_en), .rx_done_i(rx_done), .rx_shift_i(rx_shift),
    .dma_clr_i(dma_clr), .stat_rd_i(st_rd), .stat_wr_i(st_wr),
    .stat_wdata_i(st_wdata), .irq_en_i(irq_en), .rdata_o(rdata),
    .status_o(status), .rxi_o(rxi), .eri_o(eri), .rx_stall_o(rx_stall),
    .tx_stall_o(tx_stall)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Driver: one cycle of stimulus, inputs change at negedge + 2 ns.
  task automatic cycle(input logic drx, input logic [DW-1:0] b, input logic dma,
                       input logic rd, input logic wr, input logic [SW-1:0] wd,
                       input logic stby);
    @(negedge clk); #2;
    rx_en = en_q; sync_mode = sync_q; irq_en = rie_q;
    rx_done = drx; rx_shift = b; dma_clr = dma; st_rd = rd; st_wr = wr;
    st_wdata = wd; standby = stby;
    @(posedge clk); #1;
    rx_done = 1'b0; dma_clr = 1'b0; st_rd = 1'b0; st_wr = 1'b0; standby = 1'b0;
  endtask

  task automatic idle();
    cycle(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
  endtask

  // Expected outputs after the last cycle, derived from the requirements.
  task automatic expect_st(input string tag, input logic [DW-1:0] d,
                           input logic rdy, input logic ovr);
    exp_t e;
    e.tag  = tag;
    e.data = d;
    e.stat = {6'b0, ovr, rdy};
    e.rxi  = rdy & rie_q;
    e.eri  = ovr & rie_q;
    e.rst  = ovr;
    e.tst  = ovr & sync_q;
    q.push_back(e);
  endtask

  // Monitor: compares at the falling edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (rdata !== e.data || status !== e.stat || rxi !== e.rxi ||
          eri !== e.eri || rx_stall !== e.rst || tx_stall !== e.tst) begin
        errors++;
        $display("FAIL %s: got data=%h stat=%h rxi=%b eri=%b rst=%b tst=%b exp data=%h stat=%h rxi=%b eri=%b rst=%b tst=%b",
                 e.tag, rdata, status, rxi, eri, rx_stall, tx_stall,
                 e.data, e.stat, e.rxi, e.eri, e.rst, e.tst);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      errors++;
      $display("FAIL watchdog: got cycle=%0d exp completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; standby = 0; sync_mode = 0; rx_en = 0; rx_done = 0;
    rx_shift = '0; dma_clr = 0; st_rd = 0; st_wr = 0; st_wdata = '0; irq_en = 0;
    en_q = 1'b1; sync_q = 1'b0; rie_q = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(); expect_st("R1 reset", 8'h00, 0, 0);

    cycle(1, 8'hA5, 0, 0, 0, 8'h00, 0); expect_st("R2 load", 8'hA5, 1, 0);
    rie_q = 1'b1;
    idle(); expect_st("R11 rxi", 8'hA5, 1, 0);
    cycle(0, 8'h00, 0, 0, 1, 8'h00, 0); expect_st("R4 bare zero write", 8'hA5, 1, 0);
    cycle(0, 8'h00, 0, 1, 0, 8'h00, 0); expect_st("R4 read", 8'hA5, 1, 0);
    cycle(0, 8'h00, 0, 0, 1, 8'hFE, 0); expect_st("R4 armed clear", 8'hA5, 0, 0);

    cycle(1, 8'h3C, 0, 0, 0, 8'h00, 0); expect_st("R2 second load", 8'h3C, 1, 0);
    cycle(1, 8'h77, 0, 0, 0, 8'h00, 0); expect_st("R3 overrun async R8", 8'h3C, 1, 1);
    sync_q = 1'b1;
    idle(); expect_st("R8 sync stall", 8'h3C, 1, 1);
    cycle(1, 8'h11, 0, 0, 0, 8'h00, 0); expect_st("R7 rx blocked", 8'h3C, 1, 1);
    cycle(0, 8'h00, 0, 1, 0, 8'h00, 0); expect_st("R4 read both", 8'h3C, 1, 1);
    cycle(0, 8'h00, 0, 0, 1, 8'h00, 0); expect_st("R4 clear both", 8'h3C, 0, 0);
    sync_q = 1'b0;

    en_q = 1'b0;
    cycle(1, 8'h55, 0, 0, 0, 8'h00, 0); expect_st("R9 disabled rx", 8'h3C, 0, 0);
    en_q = 1'b1;
    cycle(1, 8'h66, 0, 0, 0, 8'h00, 0); expect_st("R2 load 66", 8'h66, 1, 0);
    en_q = 1'b0;
    idle(); expect_st("R9 disable keeps", 8'h66, 1, 0);
    cycle(1, 8'h99, 0, 0, 0, 8'h00, 0); expect_st("R9 disabled while full", 8'h66, 1, 0);
    en_q = 1'b1;
    cycle(0, 8'h00, 1, 0, 0, 8'h00, 0); expect_st("R6 dma clear", 8'h66, 0, 0);

    cycle(1, 8'h81, 0, 0, 0, 8'h00, 0); expect_st("R2 load 81", 8'h81, 1, 0);
    cycle(0, 8'h00, 0, 1, 0, 8'h00, 0); expect_st("R4 read 81", 8'h81, 1, 0);
    cycle(1, 8'h92, 0, 0, 1, 8'h00, 0); expect_st("R10 sw clear with rx", 8'h92, 1, 0);
    cycle(1, 8'hC3, 1, 0, 0, 8'h00, 0); expect_st("R10 dma clear with rx", 8'hC3, 1, 0);

    cycle(0, 8'h00, 0, 1, 0, 8'h00, 0); expect_st("R5 read", 8'hC3, 1, 0);
    cycle(0, 8'h00, 0, 0, 1, 8'hFF, 0); expect_st("R4 write one", 8'hC3, 1, 0);
    cycle(0, 8'h00, 0, 0, 1, 8'h00, 0); expect_st("R5 arm consumed", 8'hC3, 1, 0);

    rie_q = 1'b0;
    idle(); expect_st("R11 gated off", 8'hC3, 1, 0);
    cycle(1, 8'hD4, 0, 0, 0, 8'h00, 0); expect_st("R3 overrun again", 8'hC3, 1, 1);
    cycle(0, 8'h00, 0, 0, 0, 8'h00, 1); expect_st("R1 standby", 8'hC3, 0, 0);
    cycle(0, 8'h00, 0, 0, 1, 8'h00, 0); expect_st("R1 arms dropped", 8'hC3, 0, 0);

    wait (q.size() == 0);
    @(negedge clk); #1;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule